// File: doc/BRIEF.md
# Gamma Palette with Indexed Table Port

This block is the gamma stage of one display pipe. It holds a correction table for RGB pixels and maps each colour channel of an incoming pixel through that table. Four table formats are available: a legacy 8-bit palette, a 10-bit table, a split table, and a 12-bit table built from pairs of words. The selected format decides how a channel value becomes a table address and how the stored fields form the 16-bit output of each channel.

Software uses a simple register read/write port to load the table. It writes an index register, which can advance the index on its own, and then streams packed words through a data register. The legacy palette is a separate direct-mapped window with one word per entry. A new table format does not apply to pixels straight away: it waits for the next frame start, so no frame is looked up through two formats.

Top module: `gamma_palette`

## Requirements
- R1: After reset the programmed and active formats are 0, the index register reads 0, `reg_rdata`, `out_valid` and every output channel are 0, and legacy entry n holds n in all three channels.
- R2: Register offset 0 (`reg_addr` bit 8 clear) holds the 2-bit format code in bits 1:0. The codes are 0 legacy, 1 ten-bit, 2 split and 3 twelve-bit, and the register reads back what was written.
- R3: Register offset 1 holds the table index in bits 9:0, the auto-advance enable in bit 15 and the split-addressing flag in bit 31. All three read back as written, and the other bits read 0.
- R4: A data-register write (offset 2) stores bits 29:0 at the current index. With bit 15 set, the index then advances by one. With bit 15 clear, the index does not change.
- R5: A data-register read returns the entry at the current index, with red in bits 29:20, green in bits 19:10, blue in bits 9:0 and zeros above. With auto-advance set, the read also advances the index. Every read returns its data on `reg_rdata` one cycle after `reg_re`, and `reg_rdata` holds while no read is issued.
- R6: The index wraps to 0 after the last entry. The last entry is 511 when the split flag is set. Otherwise it is 512 when the programmed format is twelve-bit, and 1023 in all other cases.
- R7: Offsets 256 to 511 reach legacy entry `reg_addr[7:0]` directly, packed red 23:16, green 15:8, blue 7:0. A read of this window returns those 24 bits with zeros above.
- R8: The programmed format is copied to the active format only in a cycle with `frame_start` high. Pixels use the active format.
- R9: In legacy format each channel addresses legacy entry `chan[9:2]` and outputs the 8-bit value v as {v, v}.
- R10: In ten-bit format each channel addresses entry `chan` and outputs the 10-bit field f as {f, f[9:4]}.
- R11: In split format each channel addresses entry `chan[9:1]` (entries 0 to 511) and outputs {f, f[9:4]}.
- R12: In twelve-bit format channel c uses pair p = `c[9:2]` and outputs {field of entry 2p, bits 9:4 of the field of entry 2p+1}.
- R13: `out_valid` equals `pix_valid` one cycle earlier. The output channels load only on a valid pixel and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 9 | Word offset; bit 8 selects the legacy window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| frame_start | input | 1 | Frame boundary; applies the programmed format |
| pix_valid | input | 1 | Pixel qualifier |
| pix_r | input | 10 | Red channel in |
| pix_g | input | 10 | Green channel in |
| pix_b | input | 10 | Blue channel in |
| out_valid | output | 1 | Output qualifier |
| out_r | output | 16 | Corrected red |
| out_g | output | 16 | Corrected green |
| out_b | output | 16 | Corrected blue |

## Verification
Register reads and pixel results both appear one clock edge after the cycle that requests them. Register writes, index advances and format changes affect the cycle that follows their edge. The reference model in the bench follows that order at every rising edge. It first computes the read data and the pixel outputs from the state held before the edge, and only then applies the writes, the index step and the frame-start copy. The bench compares all outputs at the falling edge that follows, so each result is checked in exactly the cycle it is due.

// File: rtl/gpal_pkg.sv
package gpal_pkg;
   typedef enum logic [1:0] {
      GM_LEGACY = 2'd0,
      GM_TEN    = 2'd1,
      GM_SPLIT  = 2'd2,
      GM_TWELVE = 2'd3
   } gmode_e;

   localparam int AUTO_BIT  = 15;
   localparam int SPLIT_BIT = 31;
   localparam logic [7:0] OFS_MODE  = 8'd0;
   localparam logic [7:0] OFS_INDEX = 8'd1;
   localparam logic [7:0] OFS_DATA  = 8'd2;
endpackage

// File: rtl/gpal_index.sv
module gpal_index
   import gpal_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int IDX_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idx_wr,
   input  logic [IDX_W-1:0] idx_wval,
   input  logic             auto_wval,
   input  logic             split_wval,
   input  logic             step,
   input  gmode_e           mode_pend,
   output logic [IDX_W-1:0] idx,
   output logic             auto_en,
   output logic             split_en
);
   localparam int LIM_W = IDX_W + 1;
   logic [LIM_W-1:0] lim;
   logic [LIM_W-1:0] idx_ext;
   logic             at_end;

   always_comb begin
      if (split_en)                lim = LIM_W'(DEPTH / 2);
      else if (mode_pend == GM_TWELVE) lim = LIM_W'(DEPTH / 2 + 1);
      else                         lim = LIM_W'(DEPTH);
   end

   assign idx_ext = {1'b0, idx};
   assign at_end  = (idx_ext + LIM_W'(1)) >= lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx      <= '0;
         auto_en  <= 1'b0;
         split_en <= 1'b0;
      end else if (idx_wr) begin
         idx      <= idx_wval;
         auto_en  <= auto_wval;
         split_en <= split_wval;
      end else if (step && auto_en) begin
         idx <= at_end ? '0 : idx + IDX_W'(1);
      end
   end

   AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && auto_en && !idx_wr && idx_ext == lim - LIM_W'(1)) |=> idx == '0); // R6
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && auto_en && !idx_wr && idx_ext + LIM_W'(2) <= lim) |=> idx == $past(idx) + IDX_W'(1)); // R4
   AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!idx_wr && !(step && auto_en)) |=> $stable(idx)); // R4
endmodule

// File: rtl/gpal_table.sv
module gpal_table #(
   parameter int DEPTH     = 1024,
   parameter int IDX_W     = 10,
   parameter int WORD_W    = 30,
   parameter int LEG_DEPTH = 256,
   parameter int LEG_IDX_W = 8,
   parameter int LEG_W     = 8,
   parameter int NRD       = 6,
   parameter int NLEG      = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [IDX_W-1:0]       addr,
   input  logic [WORD_W-1:0]      wdata,
   output logic [WORD_W-1:0]      rword,
   input  logic [IDX_W-1:0]       px_addr [NRD],
   output logic [WORD_W-1:0]      px_word [NRD],
   input  logic                   leg_we,
   input  logic [LEG_IDX_W-1:0]   leg_addr,
   input  logic [3*LEG_W-1:0]     leg_wdata,
   output logic [3*LEG_W-1:0]     leg_rword,
   input  logic [LEG_IDX_W-1:0]   leg_px_addr [NLEG],
   output logic [3*LEG_W-1:0]     leg_px_word [NLEG]
);
   logic [WORD_W-1:0]  mem [DEPTH];
   logic [3*LEG_W-1:0] leg [LEG_DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int n = 0; n < LEG_DEPTH; n++) leg[n] <= {3{LEG_W'(n)}};
      end else if (leg_we) begin
         leg[leg_addr] <= leg_wdata;
      end
   end

   assign rword     = mem[addr];
   assign leg_rword = leg[leg_addr];

   for (genvar k = 0; k < NRD; k++) begin : g_rd
      assign px_word[k] = mem[px_addr[k]];
   end
   for (genvar k = 0; k < NLEG; k++) begin : g_leg_rd
      assign leg_px_word[k] = leg[leg_px_addr[k]];
   end
endmodule

// File: rtl/gpal_lookup.sv
module gpal_lookup
   import gpal_pkg::*;
#(
   parameter int CH_W  = 10,
   parameter int OUT_W = 16,
   parameter int LEG_W = 8,
   parameter int SEL   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  gmode_e            mode,
   input  logic              pix_valid,
   input  logic [CH_W-1:0]   chan,
   output logic [CH_W-1:0]   addr_a,
   output logic [CH_W-1:0]   addr_b,
   input  logic [3*CH_W-1:0] word_a,
   input  logic [3*CH_W-1:0] word_b,
   output logic [LEG_W-1:0]  leg_addr,
   input  logic [3*LEG_W-1:0] leg_word,
   output logic [OUT_W-1:0]  out
);
   localparam int LOW_W = OUT_W - CH_W;
   logic [CH_W-1:0]  fa, fb;
   logic [LEG_W-1:0] fl;
   logic [OUT_W-1:0] res;

   always_comb begin
      unique case (mode)
         GM_SPLIT:  addr_a = {1'b0, chan[CH_W-1:1]};
         GM_TWELVE: addr_a = {1'b0, chan[CH_W-1:2], 1'b0};
         default:   addr_a = chan;
      endcase
   end
   assign addr_b   = addr_a | CH_W'(1);
   assign leg_addr = chan[CH_W-1 -: LEG_W];

   assign fa = word_a[SEL*CH_W +: CH_W];
   assign fb = word_b[SEL*CH_W +: CH_W];
   assign fl = leg_word[SEL*LEG_W +: LEG_W];

   always_comb begin
      unique case (mode)
         GM_LEGACY: res = {fl, fl};
         GM_TWELVE: res = {fa, fb[CH_W-1 -: LOW_W]};
         default:   res = {fa, fa[CH_W-1 -: LOW_W]};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         out <= '0;
      else if (pix_valid) out <= res;
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> $stable(out)); // R13
endmodule

// File: rtl/gamma_palette.sv
module gamma_palette
   import gpal_pkg::*;
#(
   parameter int CH_W      = 10,
   parameter int OUT_W     = 16,
   parameter int LEG_W     = 8,
   parameter int DEPTH     = 1024,
   parameter int LEG_DEPTH = 256,
   parameter int ADDR_W    = 9,
   parameter int DATA_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_re,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              frame_start,
   input  logic              pix_valid,
   input  logic [CH_W-1:0]   pix_r,
   input  logic [CH_W-1:0]   pix_g,
   input  logic [CH_W-1:0]   pix_b,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_r,
   output logic [OUT_W-1:0]  out_g,
   output logic [OUT_W-1:0]  out_b
);
   localparam int IDX_W     = $clog2(DEPTH);
   localparam int LEG_IDX_W = $clog2(LEG_DEPTH);
   localparam int WORD_W    = 3 * CH_W;
   localparam int LWORD_W   = 3 * LEG_W;

   if (DEPTH != (1 << CH_W)) begin : g_chk_depth
      $error("DEPTH must equal 2**CH_W");
   end
   if (LEG_DEPTH != (1 << LEG_W) || LEG_W >= CH_W) begin : g_chk_leg
      $error("legacy palette must be 2**LEG_W entries with LEG_W < CH_W");
   end
   if (OUT_W != 2 * LEG_W || OUT_W - CH_W > CH_W || OUT_W <= CH_W) begin : g_chk_out
      $error("OUT_W must be 2*LEG_W and between CH_W and 2*CH_W");
   end
   if (DATA_W < 32 || ADDR_W != LEG_IDX_W + 1) begin : g_chk_bus
      $error("register port needs 32-bit data and one window bit above the legacy index");
   end

   gmode_e              mode_pend, mode_act;
   logic                in_win, sel_mode, sel_index, sel_data, data_acc;
   logic [IDX_W-1:0]    idx;
   logic                auto_en, split_en;
   logic [WORD_W-1:0]   rword;
   logic [LWORD_W-1:0]  leg_rword;
   logic [DATA_W-1:0]   rd_mux;
   logic [CH_W-1:0]     px_addr [6];
   logic [WORD_W-1:0]   px_word [6];
   logic [LEG_W-1:0]    leg_px_addr [3];
   logic [LWORD_W-1:0]  leg_px_word [3];
   logic [CH_W-1:0]     chan [3];
   logic [OUT_W-1:0]    chan_out [3];
   logic                unused_ok;

   assign in_win    = reg_addr[ADDR_W-1];
   assign sel_mode  = !in_win && reg_addr[LEG_IDX_W-1:0] == OFS_MODE;
   assign sel_index = !in_win && reg_addr[LEG_IDX_W-1:0] == OFS_INDEX;
   assign sel_data  = !in_win && reg_addr[LEG_IDX_W-1:0] == OFS_DATA;
   assign data_acc  = sel_data && (reg_we || reg_re);
   assign unused_ok = ^{reg_wdata[DATA_W-1:WORD_W], reg_wdata[AUTO_BIT-1:IDX_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_pend <= GM_LEGACY;
         mode_act  <= GM_LEGACY;
      end else begin
         if (reg_we && sel_mode) mode_pend <= gmode_e'(reg_wdata[1:0]);
         if (frame_start)        mode_act  <= mode_pend;
      end
   end

   gpal_index #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_index (
      .clk(clk), .rst_n(rst_n),
      .idx_wr(reg_we && sel_index), .idx_wval(reg_wdata[IDX_W-1:0]),
      .auto_wval(reg_wdata[AUTO_BIT]), .split_wval(reg_wdata[SPLIT_BIT]),
      .step(data_acc), .mode_pend(mode_pend),
      .idx(idx), .auto_en(auto_en), .split_en(split_en)
   );

   gpal_table #(.DEPTH(DEPTH), .IDX_W(IDX_W), .WORD_W(WORD_W), .LEG_DEPTH(LEG_DEPTH),
                .LEG_IDX_W(LEG_IDX_W), .LEG_W(LEG_W), .NRD(6), .NLEG(3)) u_table (
      .clk(clk), .rst_n(rst_n),
      .we(reg_we && sel_data), .addr(idx), .wdata(reg_wdata[WORD_W-1:0]), .rword(rword),
      .px_addr(px_addr), .px_word(px_word),
      .leg_we(reg_we && in_win), .leg_addr(reg_addr[LEG_IDX_W-1:0]),
      .leg_wdata(reg_wdata[LWORD_W-1:0]), .leg_rword(leg_rword),
      .leg_px_addr(leg_px_addr), .leg_px_word(leg_px_word)
   );

   assign chan[0] = pix_b;
   assign chan[1] = pix_g;
   assign chan[2] = pix_r;

   for (genvar c = 0; c < 3; c++) begin : g_chan
      gpal_lookup #(.CH_W(CH_W), .OUT_W(OUT_W), .LEG_W(LEG_W), .SEL(c)) u_lookup (
         .clk(clk), .rst_n(rst_n), .mode(mode_act), .pix_valid(pix_valid),
         .chan(chan[c]), .addr_a(px_addr[2*c]), .addr_b(px_addr[2*c+1]),
         .word_a(px_word[2*c]), .word_b(px_word[2*c+1]),
         .leg_addr(leg_px_addr[c]), .leg_word(leg_px_word[c]), .out(chan_out[c])
      );
   end

   assign out_b = chan_out[0];
   assign out_g = chan_out[1];
   assign out_r = chan_out[2];

   always_comb begin
      rd_mux = '0;
      if (in_win)         rd_mux[LWORD_W-1:0] = leg_rword;
      else if (sel_mode)  rd_mux[1:0] = mode_pend;
      else if (sel_index) begin
         rd_mux[IDX_W-1:0] = idx;
         rd_mux[AUTO_BIT]  = auto_en;
         rd_mux[SPLIT_BIT] = split_en;
      end
      else if (sel_data)  rd_mux[WORD_W-1:0] = rword;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
         out_valid <= 1'b0;
      end else begin
         if (reg_re) reg_rdata <= rd_mux;
         out_valid <= pix_valid;
      end
   end

   AST_MODE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(mode_act)); // R8
   AST_MODE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> mode_act == $past(mode_pend)); // R8
   AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> out_valid == $past(pix_valid)); // R13
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_re |=> $stable(reg_rdata)); // R5
endmodule

// File: tb/gamma_palette_tb.sv
module gamma_palette_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 0, reg_re = 0, frame_start = 0, pix_valid = 0;
   logic [8:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [9:0]  pix_r = '0, pix_g = '0, pix_b = '0;
   logic [31:0] reg_rdata;
   logic        out_valid;
   logic [15:0] out_r, out_g, out_b;

   always #2.5 clk = ~clk;

   gamma_palette u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
      .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
      .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
   );

   // behavioural reference state
   int tbl [1024];
   int leg [256];
   int mode_p, mode_a, idx, auto_f, split_f;
   int e_rd, e_ov, e_r, e_g, e_b;
   bit model_ok = 0;
   string phase = "R1";
   int checks = 0, errors = 0;
   bit done = 0;

   function automatic int fld(int w, int sel);
      return (w >> (10 * sel)) & 1023;
   endfunction

   function automatic int lookup(int c, int sel);
      int f, g;
      case (mode_a)
         0: begin f = (leg[c / 4] >> (8 * sel)) & 255; return f * 257; end
         1: begin f = fld(tbl[c], sel); return f * 64 + f / 16; end
         2: begin f = fld(tbl[c / 2], sel); return f * 64 + f / 16; end
         default: begin
            f = fld(tbl[(c / 4) * 2], sel);
            g = fld(tbl[(c / 4) * 2 + 1], sel);
            return f * 64 + g / 16;
         end
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int n = 0; n < 256; n++) leg[n] = n * 65793;
         mode_p = 0; mode_a = 0; idx = 0; auto_f = 0; split_f = 0;
         e_rd = 0; e_ov = 0; e_r = 0; e_g = 0; e_b = 0;
         model_ok = 1;
      end else begin
         int a, lim;
         bit dacc;
         a = int'(reg_addr);
         if (reg_re) begin
            if (a >= 256)    e_rd = leg[a - 256];
            else if (a == 0) e_rd = mode_p;
            else if (a == 1) e_rd = (split_f << 31) | (auto_f << 15) | idx;
            else if (a == 2) e_rd = tbl[idx];
            else             e_rd = 0;
         end
         e_ov = pix_valid;
         if (pix_valid) begin
            e_r = lookup(int'(pix_r), 2);
            e_g = lookup(int'(pix_g), 1);
            e_b = lookup(int'(pix_b), 0);
         end
         lim = split_f ? 512 : (mode_p == 3 ? 513 : 1024);
         dacc = (a == 2) && (reg_we || reg_re);
         if (reg_we) begin
            if (a >= 256)    leg[a - 256] = int'(reg_wdata) & 'hFFFFFF;
            else if (a == 0) mode_p = int'(reg_wdata) & 3;
            else if (a == 1) begin
               idx = int'(reg_wdata) & 1023;
               auto_f = int'(reg_wdata[15]);
               split_f = int'(reg_wdata[31]);
            end
            else if (a == 2) tbl[idx] = int'(reg_wdata) & 'h3FFFFFFF;
         end
         if (dacc && auto_f && !(reg_we && a == 1)) idx = (idx + 1 >= lim) ? 0 : idx + 1;
         if (frame_start) mode_a = mode_p;
      end
   end

   always @(negedge clk) begin
      if (rst_n && model_ok && !done) begin
         checks++;
         if (reg_rdata !== 32'(e_rd) || out_valid !== 1'(e_ov) || out_r !== 16'(e_r) ||
             out_g !== 16'(e_g) || out_b !== 16'(e_b)) begin
            errors++;
            $display("FAIL %s: actual rd=%h v=%b r=%h g=%h b=%h expected rd=%h v=%b r=%h g=%h b=%h",
                     phase, reg_rdata, out_valid, out_r, out_g, out_b,
                     32'(e_rd), 1'(e_ov), 16'(e_r), 16'(e_g), 16'(e_b));
         end
      end
   end

   task automatic idle();
      @(negedge clk); #1;
      reg_we = 0; reg_re = 0; frame_start = 0; pix_valid = 0;
   endtask
   task automatic wr(input int a, input int d);
      @(negedge clk); #1;
      reg_we = 1; reg_re = 0; reg_addr = 9'(a); reg_wdata = 32'(d);
      frame_start = 0; pix_valid = 0;
   endtask
   task automatic rd(input int a);
      @(negedge clk); #1;
      reg_we = 0; reg_re = 1; reg_addr = 9'(a); frame_start = 0; pix_valid = 0;
   endtask
   task automatic fs();
      @(negedge clk); #1;
      reg_we = 0; reg_re = 0; frame_start = 1; pix_valid = 0;
   endtask
   task automatic px(input int r, input int g, input int b);
      @(negedge clk); #1;
      reg_we = 0; reg_re = 0; frame_start = 0; pix_valid = 1;
      pix_r = 10'(r); pix_g = 10'(g); pix_b = 10'(b);
   endtask
   task automatic sweep();
      for (int k = 0; k < 40; k++) px((k * 27) % 1024, 1023 - k * 26, (k * 101) & 1023);
      px(1023, 0, 511);
      idle();
   endtask
   function automatic int pat(int i);
      return (((i * 37 + 11) & 1023) << 20) | (((i * 91 + 5) & 1023) << 10) | (((i * 13) ^ 'h155) & 1023);
   endfunction

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      idle();
      phase = "R1";
      rd(0); rd(1); rd(256); rd(256 + 128); rd(511);
      px(0, 512, 1023); px(4, 8, 12); idle();
      phase = "R2";
      wr(0, 2); rd(0); wr(0, 'hFFFF_FFF1); rd(0);
      phase = "R3";
      wr(1, 32'h8000_8005); rd(1); wr(1, 'h7FFF_0203); rd(1); wr(1, 'h8000); rd(1);
      phase = "R4";
      for (int i = 0; i < 1024; i++) wr(2, pat(i) | 32'hC000_0000);
      rd(1);
      wr(1, 7); wr(2, 'h1234567); wr(2, 'h2345678); rd(1); rd(2);
      phase = "R5";
      wr(1, 'h8000 | 1020);
      for (int i = 0; i < 6; i++) rd(2);
      rd(1); wr(1, 3); rd(2); rd(2); rd(1);
      phase = "R6";
      wr(0, 3); wr(1, 'h8000 | 511);
      wr(2, 'h0ABCDEF); wr(2, 'h1FEDCBA); wr(2, 'h3333333); rd(1);
      wr(1, 32'h8000_8000 | 510); rd(2); rd(2); rd(2); rd(1);
      wr(0, 1); wr(1, 'h8000 | 1023); wr(2, pat(1023)); rd(1);
      phase = "R7";
      wr(256 + 10, 'hFF00_A1B2C3); rd(256 + 10); rd(256 + 11); wr(256 + 255, 'h0F0F0F); rd(511);
      phase = "R8";
      wr(0, 3); px(40, 44, 1020); idle(); rd(0);
      fs(); px(40, 44, 1020); idle();
      phase = "R12";
      sweep();
      phase = "R10";
      wr(0, 1); fs(); sweep();
      phase = "R11";
      wr(0, 2); fs(); sweep();
      phase = "R9";
      wr(0, 0); fs(); sweep();
      px(40, 41, 1020); idle();
      phase = "R13";
      px(100, 200, 300); idle(); idle(); px(5, 6, 7); px(900, 800, 700); idle(); idle();
      idle();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog %s: actual=timeout expected=completion", phase);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule